// File: doc/BRIEF.md
# Byte RAM with Single-Error Correction and Background Scrubbing

This block stores bytes in a small internal array, each protected by four check bits of a (12,8) Hamming code. The check bits are generated by an XOR network on every write. Every read recomputes a 4-bit syndrome over the stored 12-bit word. When the syndrome names one of the twelve stored positions, that bit is flipped back before the byte is returned. When the syndrome names a position that does not exist, the word is flagged as uncorrectable.

A scrubber shares the single array port with the request port and runs only when `scrub_en` is high. It visits every address in turn. For each address it reads the word, decodes it, and writes a freshly encoded, corrected word back when a correction was needed. This clears single-bit upsets before a second upset can land in the same word, which the code could not repair. Requests always win the port. The scrubber is a small state machine with three states:
- `SC_IDLE`: scrubbing is disabled. It moves to `SC_CHECK` when `scrub_en` rises.
- `SC_CHECK`: decode the word at the scrub address. With no request it captures the result and moves to `SC_FIX`. With a request it stays in `SC_CHECK`. When `scrub_en` is low it returns to `SC_IDLE`.
- `SC_FIX`: write back if needed and advance the address. With a request it drops back to `SC_CHECK` and keeps the same address. Otherwise it goes to `SC_CHECK`, or to `SC_IDLE` if `scrub_en` is low.

The `inj_mask` input is a test hook. It is XORed into the encoded word during a request write, so that faults can be placed in storage through the normal port.

Top module: `hecc_scrub_ram`

## Requirements
- R1: A request write stores the byte with four check bits. The check bits sit at codeword positions 1, 2, 4 and 8. The data bits d0..d7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. A later read of a clean word returns the byte with both error flags low.
- R2: If exactly one of the 12 stored bits of a word is flipped, a read returns the original byte and pulses `err_corr`.
- R3: A syndrome of 13, 14 or 15 pulses `err_uncorr`. In that case the byte is returned as stored, without correction.
- R4: `rd_valid`, `rd_data` and the error flags of a read appear on the cycle after the read request. `rd_valid` is low for writes and on idle cycles.
- R5: With `scrub_en` high, every address is read and corrected words are written back. A later read of a scrubbed word shows no error. Each scrub access that corrected a bit pulses `err_corr`.
- R6: A request takes the array port ahead of the scrubber. The scrub address does not advance on any cycle with a request.
- R7: After address 2^ADDR_W-1 the scrubber wraps to address 0. `scrub_done` pulses for one cycle at the end of each full pass.
- R8: `err_corr`, `err_uncorr` and `scrub_done` are single-cycle pulses. `err_corr` and `err_uncorr` are never high together.
- R9: After reset all outputs are low and the scrub address is 0.
- R10: With `scrub_en` low, storage is left untouched. A fault injected earlier is still reported on a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 8 | Write byte |
| inj_mask | input | 12 | Bits XORed into the stored word on a request write (test hook) |
| scrub_en | input | 1 | Enables the background scrubber |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Corrected read byte |
| err_corr | output | 1 | Pulse: an access needed a single-bit correction |
| err_uncorr | output | 1 | Pulse: an access found an uncorrectable syndrome |
| scrub_done | output | 1 | Pulse: the scrubber finished a full pass |

## Verification
The in-RTL assertions check the following on every cycle:
- the one-cycle read response, and its absence on writes and idle cycles;
- exclusivity and single-cycle width of the flags;
- the scrub address held still under requests;
- `scrub_done` coinciding with the wrap to address 0.

Only the bench scenarios can show the rest:
- that correction is right for every one of the twelve flip positions;
- that the uncorrectable syndromes return raw data;
- that a scrub pass actually repairs storage, with one correction pulse per faulty word;
- that exactly one pass completes in a window;
- that continuous requests starve the scrubber.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    localparam int DW = 8;
    localparam int CW = 12;
    localparam int SW = 4;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_CHECK,
        SC_FIX
    } scrub_state_e;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Codeword bit [p-1] holds position p (1-based).
    function automatic logic [CW-1:0] hecc_encode(input logic [DW-1:0] d);
        logic [CW-1:0] cw;
        int j;
        cw = '0;
        j  = 0;
        for (int p = 1; p <= CW; p++) begin
            if (!is_pow2(p)) begin
                cw[p-1] = d[j];
                j++;
            end
        end
        for (int k = 0; k < SW; k++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= CW; p++) begin
                if (((p >> k) & 1) == 1 && !is_pow2(p)) par ^= cw[p-1];
            end
            cw[(1 << k) - 1] = par;
        end
        return cw;
    endfunction

    function automatic logic [SW-1:0] hecc_syndrome(input logic [CW-1:0] cw);
        logic [SW-1:0] s;
        s = '0;
        for (int k = 0; k < SW; k++) begin
            for (int p = 1; p <= CW; p++) begin
                if (((p >> k) & 1) == 1) s[k] ^= cw[p-1];
            end
        end
        return s;
    endfunction

    function automatic logic [DW-1:0] hecc_extract(input logic [CW-1:0] cw);
        logic [DW-1:0] d;
        int j;
        d = '0;
        j = 0;
        for (int p = 1; p <= CW; p++) begin
            if (!is_pow2(p)) begin
                d[j] = cw[p-1];
                j++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/hecc_encoder.sv
module hecc_encoder
    import hecc_pkg::*;
(
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] code_o
);
    always_comb code_o = hecc_encode(data_i);
endmodule

// File: rtl/hecc_decoder.sv
module hecc_decoder
    import hecc_pkg::*;
(
    input  logic [CW-1:0] code_i,
    output logic [DW-1:0] data_o,
    output logic          corr_o,
    output logic          uncorr_o
);
    logic [SW-1:0] syn;
    logic [CW-1:0] fixed;

    always_comb begin
        syn      = hecc_syndrome(code_i);
        corr_o   = (syn != '0) && (int'(syn) <= CW);
        uncorr_o = int'(syn) > CW;
        for (int p = 1; p <= CW; p++) begin
            fixed[p-1] = code_i[p-1] ^ (corr_o && (int'(syn) == p));
        end
        data_o = hecc_extract(fixed);
    end
endmodule

// File: rtl/hecc_array.sv
module hecc_array
    import hecc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CW-1:0]     wdata_i,
    output logic [CW-1:0]     rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wdata_i;
    end

    assign rdata_o = mem[addr_i];
endmodule

// File: rtl/hecc_scrub_ctrl.sv
module hecc_scrub_ctrl
    import hecc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scrub_en_i,
    input  logic              req_i,
    input  logic [DW-1:0]     dec_data_i,
    input  logic              dec_corr_i,
    input  logic              dec_uncorr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wb_en_o,
    output logic [DW-1:0]     wb_data_o,
    output logic              corr_o,
    output logic              uncorr_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    scrub_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]     data_q;
    logic              corr_q, unc_q;
    logic              capture, fix_go;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        fix_go  = 1'b0;
        unique case (state_q)
            SC_IDLE: begin
                if (scrub_en_i) state_d = SC_CHECK;
            end
            SC_CHECK: begin
                if (!scrub_en_i) state_d = SC_IDLE;
                else if (!req_i) begin
                    capture = 1'b1;
                    state_d = SC_FIX;
                end
            end
            SC_FIX: begin
                if (req_i) state_d = SC_CHECK;
                else begin
                    fix_go  = 1'b1;
                    state_d = scrub_en_i ? SC_CHECK : SC_IDLE;
                end
            end
            default: state_d = SC_IDLE;
        endcase
        wb_en_o   = fix_go && corr_q;
        wb_data_o = data_q;
        corr_o    = fix_go && corr_q;
        uncorr_o  = fix_go && unc_q;
        done_o    = fix_go && (addr_q == LAST);
        addr_o    = addr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            corr_q <= 1'b0;
            unc_q  <= 1'b0;
        end else begin
            if (capture) begin
                data_q <= dec_data_i;
                corr_q <= dec_corr_i;
                unc_q  <= dec_uncorr_i;
            end
            if (fix_go) addr_q <= addr_q + 1'b1;
        end
    end

    // R6: no advance while a request holds the port
    a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> $stable(addr_q));
    // R5: write-back only comes out of the fix state
    a_r5_wb_in_fix: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (state_q == SC_FIX) && !req_i);
endmodule

// File: rtl/hecc_scrub_ram.sv
module hecc_scrub_ram
    import hecc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [CW-1:0]     inj_mask,
    input  logic              scrub_en,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              err_corr,
    output logic              err_uncorr,
    output logic              scrub_done
);
    logic [ADDR_W-1:0] sc_addr, port_addr;
    logic              sc_wb, sc_corr, sc_unc, sc_done;
    logic [DW-1:0]     sc_wdata, enc_in, dec_data;
    logic [CW-1:0]     enc_out, arr_wdata, arr_rdata;
    logic              arr_we, dec_corr, dec_unc, rd_req;

    assign rd_req    = req_valid && !req_we;
    assign port_addr = req_valid ? req_addr : sc_addr;
    assign enc_in    = req_valid ? req_wdata : sc_wdata;
    assign arr_we    = (req_valid && req_we) || sc_wb;
    assign arr_wdata = req_valid ? (enc_out ^ inj_mask) : enc_out;

    hecc_encoder u_enc (.data_i(enc_in), .code_o(enc_out));

    hecc_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .we_i(arr_we), .addr_i(port_addr),
        .wdata_i(arr_wdata), .rdata_o(arr_rdata)
    );

    hecc_decoder u_dec (
        .code_i(arr_rdata), .data_o(dec_data),
        .corr_o(dec_corr), .uncorr_o(dec_unc)
    );

    hecc_scrub_ctrl #(.ADDR_W(ADDR_W)) u_scrub (
        .clk(clk), .rst_n(rst_n), .scrub_en_i(scrub_en), .req_i(req_valid),
        .dec_data_i(dec_data), .dec_corr_i(dec_corr), .dec_uncorr_i(dec_unc),
        .addr_o(sc_addr), .wb_en_o(sc_wb), .wb_data_o(sc_wdata),
        .corr_o(sc_corr), .uncorr_o(sc_unc), .done_o(sc_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            err_corr   <= 1'b0;
            err_uncorr <= 1'b0;
            scrub_done <= 1'b0;
        end else begin
            rd_valid   <= rd_req;
            if (rd_req) rd_data <= dec_data;
            err_corr   <= (rd_req && dec_corr) || sc_corr;
            err_uncorr <= (rd_req && dec_unc) || sc_unc;
            scrub_done <= sc_done;
        end
    end

    // R4: read response one cycle after a read request
    a_r4_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    // R8: flags exclusive and single-cycle
    a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_corr && err_uncorr));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_done |=> !scrub_done);
    // R7: pass end coincides with wrap to address zero
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_done |-> (sc_addr == '0));
endmodule

// File: tb/hecc_scrub_ram_bench.sv
module hecc_scrub_ram_bench;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_we = 1'b0, scrub_en = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic [11:0]   inj_mask = '0;
    logic          rd_valid, err_corr, err_uncorr, scrub_done;
    logic [7:0]    rd_data;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hecc_scrub_ram #(.ADDR_W(AW)) u_hecc_scrub_ram (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .inj_mask(inj_mask),
        .scrub_en(scrub_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .err_corr(err_corr), .err_uncorr(err_uncorr), .scrub_done(scrub_done)
    );

    // {addr, wdata, mask, exp_data, exp_corr, exp_uncorr}
    localparam logic [33:0] VEC [16] = '{
        {4'd0,  8'h3C, 12'h000, 8'h3C, 1'b0, 1'b0},
        {4'd1,  8'h11, 12'h001, 8'h11, 1'b1, 1'b0},
        {4'd2,  8'hA7, 12'h002, 8'hA7, 1'b1, 1'b0},
        {4'd3,  8'hFF, 12'h004, 8'hFF, 1'b1, 1'b0},
        {4'd4,  8'h01, 12'h008, 8'h01, 1'b1, 1'b0},
        {4'd5,  8'h80, 12'h010, 8'h80, 1'b1, 1'b0},
        {4'd6,  8'h55, 12'h020, 8'h55, 1'b1, 1'b0},
        {4'd7,  8'hAA, 12'h040, 8'hAA, 1'b1, 1'b0},
        {4'd8,  8'h00, 12'h080, 8'h00, 1'b1, 1'b0},
        {4'd9,  8'h96, 12'h100, 8'h96, 1'b1, 1'b0},
        {4'd10, 8'h4B, 12'h200, 8'h4B, 1'b1, 1'b0},
        {4'd11, 8'hC3, 12'h400, 8'hC3, 1'b1, 1'b0},
        {4'd12, 8'h7E, 12'h800, 8'h7E, 1'b1, 1'b0},
        {4'd13, 8'h5A, 12'h090, 8'h58, 1'b0, 1'b1},
        {4'd14, 8'hF0, 12'h120, 8'hE4, 1'b0, 1'b1},
        {4'd15, 8'h00, 12'h000, 8'h00, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d,
                            input logic [11:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d; inj_mask = m;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0; inj_mask = '0;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int ncorr, nunc, ndone;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9", "rd_valid", rd_valid, 0);
        chk("R9", "flags", {err_corr, err_uncorr, scrub_done}, 0);
        chk("R9", "rd_data", rd_data, 0);

        // Table: R1 clean, R2 every single flip, R3 uncorrectable, R10 scrub off
        for (int i = 0; i < 16; i++) begin
            do_write(VEC[i][33:30], VEC[i][29:22], VEC[i][21:10]);
            chk("R4", "rd_valid after write", rd_valid, 0);
        end
        for (int i = 0; i < 16; i++) begin
            do_read(VEC[i][33:30]);
            chk("R4", "rd_valid", rd_valid, 1);
            chk(VEC[i][1] ? "R2" : (VEC[i][0] ? "R3" : "R1"), "rd_data",
                rd_data, VEC[i][9:2]);
            chk("R2", "err_corr", err_corr, VEC[i][1]);
            chk("R3", "err_uncorr", err_uncorr, VEC[i][0]);
            @(negedge clk);
            chk("R8", "flags one cycle", {err_corr, err_uncorr, rd_valid}, 0);
        end
        // R10: scrub disabled, fault still present on reread
        do_read(4'd7);
        chk("R10", "fault kept", err_corr, 1);

        // Scrub pass: clean fill, two faults
        for (int i = 0; i < 16; i++) do_write(AW'(i), 8'(i * 17), 12'h000);
        do_write(4'd7, 8'h77, 12'h040);
        do_write(4'd9, 8'h99, 12'h004);
        ncorr = 0; nunc = 0; ndone = 0;
        scrub_en = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            ncorr += int'(err_corr); nunc += int'(err_uncorr); ndone += int'(scrub_done);
        end
        scrub_en = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            ncorr += int'(err_corr); nunc += int'(err_uncorr); ndone += int'(scrub_done);
        end
        chk("R5", "scrub corrections", ncorr, 2);
        chk("R5", "scrub uncorrectable", nunc, 0);
        chk("R7", "done pulses in one pass", ndone, 1);
        do_read(4'd7);
        chk("R5", "addr7 data", rd_data, 8'h77);
        chk("R5", "addr7 repaired", err_corr, 0);
        do_read(4'd9);
        chk("R5", "addr9 data", rd_data, 8'h99);
        chk("R5", "addr9 repaired", err_corr, 0);

        // R6: continuous requests starve the scrubber
        scrub_en = 1'b1;
        ndone = 0; ncorr = 0;
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = 4'd7;
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            ndone += int'(scrub_done);
            chk("R6", "read under scrub", rd_data, 8'h77);
        end
        req_valid = 1'b0;
        chk("R6", "no pass while busy", ndone, 0);
        ndone = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            ndone += int'(scrub_done); ncorr += int'(err_corr);
        end
        chk("R7", "pass resumes and wraps", ndone, 1);
        chk("R5", "no new corrections", ncorr, 0);
        scrub_en = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule